// File: doc/BRIEF.md
# Interrupt Enable and Timing Status Registers

This block is a small memory-mapped control and status unit for a processor whose work is paced by a video beam. It holds the enable bits for the non-maskable interrupt, for the vertical and horizontal timer interrupts and for an automatic controller poll. It keeps a sticky NMI flag and a sticky IRQ flag, which are set by rising edges on raw event inputs and cleared when they are read. It also reports blanking status taken from the beam counters. It produces one-cycle interrupt request pulses. A write to the enable register can raise a request again when a flag is already pending.

The register bus is a 2-bit select with separate read and write strobes. Read data is registered and is valid on the cycle after the read strobe. Bits that a register does not define return the last byte seen on the bus. That byte is the most recent value written, or the most recent value returned by a read. Comparing the counters against programmed trigger positions, and the controller poll engine, are handled outside this block.

Top module: `irq_timing_regs`

## Requirements
- R1: A write to select 0 (control) loads enable outputs from data bits: bit 7 to `nmi_en`, bit 5 to `virq_en`, bit 4 to `hirq_en`, bit 0 to `autopoll_en`; other bits are ignored. Every enable, flag, request and `rd_data` is 0 after reset.
- R2: A rising edge on `nmi_evt` sets the NMI flag. When `nmi_en` is 1, it also pulses `nmi_req` high for exactly one cycle.
- R3: A control write that changes NMI enable from 0 to 1 while the NMI flag is set pulses `nmi_req`. A control write that leaves an already-set enable at 1 does not.
- R4: A rising edge on `irq_evt` sets the IRQ flag. It pulses `irq_req` when `virq_en` or `hirq_en` is 1.
- R5: A control write that leaves vertical IRQ enabled and horizontal IRQ disabled while the IRQ flag is set pulses `irq_req`. A write with both enabled does not.
- R6: A control write with data bits 5 and 4 both 0 clears the IRQ flag. It also suppresses any `irq_req` in the following cycle, even if an IRQ event arrives in the same cycle.
- R7: A read of select 1 returns {NMI flag, last bus bits 6:4, 4'h2}, then clears the NMI flag.
- R8: A read of select 2 returns {IRQ flag, last bus bits 6:0}, then clears the IRQ flag.
- R9: When an event edge arrives in the same cycle as a read of its flag, the read returns the old flag value and the flag ends up set.
- R10: A read of select 3 (status) sets bit 7 when `vcount` is at or above the blank start line, and bit 0 when `vcount` is within the first three blank lines. The blank start line is 225, or 240 when `overscan` is 1.
- R11: Status bit 6 is 1 when `hcount` is 2 or less, or 1096 or more. Status bits 5:1 are the last bus bits 5:1.
- R12: The last bus value is updated by every write (to the written byte) and by every read (to the returned byte). A read of select 0 returns it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 NMI flag, 2 IRQ flag, 3 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (ignored when wr_en is high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| hcount | input | 11 | Horizontal beam counter |
| vcount | input | 9 | Vertical beam counter |
| overscan | input | 1 | Selects the later blank start line |
| nmi_evt | input | 1 | Raw NMI event level |
| irq_evt | input | 1 | Raw IRQ event level |
| nmi_req | output | 1 | One-cycle NMI request pulse |
| irq_req | output | 1 | One-cycle IRQ request pulse |
| nmi_en | output | 1 | NMI enable |
| virq_en | output | 1 | Vertical IRQ enable |
| hirq_en | output | 1 | Horizontal IRQ enable |
| autopoll_en | output | 1 | Automatic poll enable |

## Verification
The assertions check the following properties on every cycle:
- the clearing effect of flag reads, and that an event edge wins over a concurrent clear;
- that a write disabling both IRQ sources silences the IRQ path;
- that an NMI request never appears without the NMI enable;
- that the first-blank-lines bit in status never appears without the in-blank bit.

The bench scenarios cover the rest:
- the exact boundary lines for both overscan settings;
- the horizontal window edges;
- the propagation of the last bus byte into undefined bits;
- the re-trigger cases, which depend on a history of writes and events.

// File: rtl/irq_timing_regs.sv
module irq_timing_regs #(
  parameter int HW          = 11,
  parameter int VW          = 9,
  parameter int VB_NORMAL   = 225,
  parameter int VB_OVERSCAN = 240,
  parameter int HB_EARLY    = 2,
  parameter int HB_LATE     = 1096,
  parameter int REVISION    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          overscan,
  input  logic          nmi_evt,
  input  logic          irq_evt,
  output logic          nmi_req,
  output logic          irq_req,
  output logic          nmi_en,
  output logic          virq_en,
  output logic          hirq_en,
  output logic          autopoll_en
);
  localparam logic [VW-1:0] VB_N = VB_NORMAL[VW-1:0];
  localparam logic [VW-1:0] VB_O = VB_OVERSCAN[VW-1:0];
  localparam logic [HW-1:0] H_LO = HB_EARLY[HW-1:0];
  localparam logic [HW-1:0] H_HI = HB_LATE[HW-1:0];
  localparam logic [3:0]    REV  = REVISION[3:0];

  logic [7:0] last_bus;
  logic nmi_flag, irq_flag, nmi_evt_q, irq_evt_q;
  logic [7:0] rd_value;

  wire ctl_wr  = wr_en && reg_addr == 2'd0;
  wire rd_ok   = rd_en && !wr_en;
  wire rd_nmi  = rd_ok && reg_addr == 2'd1;
  wire rd_irq  = rd_ok && reg_addr == 2'd2;
  wire nmi_set = nmi_evt && !nmi_evt_q;
  wire irq_set = irq_evt && !irq_evt_q;
  wire irq_off = ctl_wr && !wr_data[5] && !wr_data[4];

  wire [VW-1:0] vb_line  = overscan ? VB_O : VB_N;
  wire          in_vb    = vcount >= vb_line;
  wire [VW-1:0] vb_depth = vcount - vb_line;
  wire          vb_early = in_vb && vb_depth < VW'(3);
  wire          in_hb    = hcount <= H_LO || hcount >= H_HI;

  always_comb begin
    case (reg_addr)
      2'd1:    rd_value = {nmi_flag, last_bus[6:4], REV};
      2'd2:    rd_value = {irq_flag, last_bus[6:0]};
      2'd3:    rd_value = {in_vb, in_hb, last_bus[5:1], vb_early};
      default: rd_value = last_bus;
    endcase
  end

  wire nmi_retrig = ctl_wr && !nmi_en && wr_data[7] && nmi_flag;
  wire irq_retrig = ctl_wr && wr_data[5] && !wr_data[4] && irq_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_bus    <= '0;
      rd_data     <= '0;
      nmi_flag    <= 1'b0;
      irq_flag    <= 1'b0;
      nmi_evt_q   <= 1'b0;
      irq_evt_q   <= 1'b0;
      nmi_req     <= 1'b0;
      irq_req     <= 1'b0;
      nmi_en      <= 1'b0;
      virq_en     <= 1'b0;
      hirq_en     <= 1'b0;
      autopoll_en <= 1'b0;
    end else begin
      nmi_evt_q <= nmi_evt;
      irq_evt_q <= irq_evt;
      if (wr_en) last_bus <= wr_data;
      else if (rd_ok) begin
        last_bus <= rd_value;
        rd_data  <= rd_value;
      end
      if (ctl_wr) begin
        nmi_en      <= wr_data[7];
        virq_en     <= wr_data[5];
        hirq_en     <= wr_data[4];
        autopoll_en <= wr_data[0];
      end
      if (nmi_set)     nmi_flag <= 1'b1;
      else if (rd_nmi) nmi_flag <= 1'b0;
      if (irq_off)     irq_flag <= 1'b0;
      else if (irq_set) irq_flag <= 1'b1;
      else if (rd_irq) irq_flag <= 1'b0;
      nmi_req <= (nmi_set && nmi_en) || nmi_retrig;
      irq_req <= !irq_off && ((irq_set && (virq_en || hirq_en)) || irq_retrig);
    end
  end
endmodule

// File: rtl/irq_timing_regs_chk.sv
module irq_timing_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       nmi_req,
  input logic       irq_req,
  input logic       nmi_en,
  input logic       nmi_flag,
  input logic       irq_flag,
  input logic       nmi_set,
  input logic       irq_set
);
  assert_nmi_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && reg_addr == 2'd1 |=> rd_data[3:0] == 4'h2);
  assert_nmi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && reg_addr == 2'd1 && !nmi_set |=> !nmi_flag);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && reg_addr == 2'd2 && !irq_set |=> !irq_flag);
  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_addr == 2'd0 && !wr_data[5] && !wr_data[4] |=> !irq_req && !irq_flag);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> nmi_flag);
  assert_nmi_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_en || $past(nmi_en));
  assert_vb_nest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && reg_addr == 2'd3 |=> !rd_data[0] || rd_data[7]);
endmodule

bind irq_timing_regs irq_timing_regs_chk chk (.*);

// File: tb/irq_timing_regs_test.sv
module irq_timing_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [10:0] hcount = '0;
  logic [8:0] vcount = '0;
  logic overscan = 1'b0, nmi_evt = 1'b0, irq_evt = 1'b0;
  logic nmi_req, irq_req, nmi_en, virq_en, hirq_en, autopoll_en;
  int checks = 0, failures = 0;
  logic [7:0] bus_q = 8'h00;
  logic [7:0] got;

  always #5 clk = ~clk;

  irq_timing_regs uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    bus_q = d;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); reg_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    got = rd_data;
    bus_q = rd_data;
  endtask

  task automatic pulse_nmi;
    @(negedge clk); nmi_evt = 1'b1;
    @(negedge clk); nmi_evt = 1'b0;
  endtask

  task automatic pulse_irq;
    @(negedge clk); irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", {nmi_en, virq_en, hirq_en, autopoll_en, nmi_req, irq_req, 2'b00}, 8'h00);
    check("R1 reset rd_data", rd_data, 8'h00);
  endtask

  task automatic t_enables;
    wr(2'd0, 8'hB1);
    check("R1 enables set", {4'h0, nmi_en, virq_en, hirq_en, autopoll_en}, 8'h0F);
    wr(2'd0, 8'h4E);
    check("R1 ignored bits", {4'h0, nmi_en, virq_en, hirq_en, autopoll_en}, 8'h00);
  endtask

  task automatic t_nmi;
    pulse_nmi();
    check("R2 no req when disabled", {7'h0, nmi_req}, 8'h00);
    rd(2'd1);
    check("R7 nmi read set", got, 8'hC2);
    rd(2'd1);
    check("R7 nmi read cleared", got, 8'h42);
    wr(2'd0, 8'h80);
    check("R3 no retrigger without flag", {7'h0, nmi_req}, 8'h00);
    pulse_nmi();
    check("R2 req pulse", {7'h0, nmi_req}, 8'h01);
    @(negedge clk);
    check("R2 req one cycle", {7'h0, nmi_req}, 8'h00);
    rd(2'd1);
  endtask

  task automatic t_nmi_retrig;
    wr(2'd0, 8'h00);
    pulse_nmi();
    wr(2'd0, 8'h80);
    check("R3 retrigger on enable", {7'h0, nmi_req}, 8'h01);
    wr(2'd0, 8'h80);
    check("R3 no retrigger when already enabled", {7'h0, nmi_req}, 8'h00);
    rd(2'd1);
    check("R7 flag shown", got[7:0], {1'b1, 8'h80 >> 1 & 8'h00 | 3'b000, 4'h2} | 8'h80);
  endtask

  task automatic t_irq;
    wr(2'd0, 8'h00);
    pulse_irq();
    check("R4 no req when disabled", {7'h0, irq_req}, 8'h00);
    rd(2'd2);
    check("R8 irq read set", got, 8'h80);
    rd(2'd2);
    check("R8 irq read cleared", got, 8'h00);
    wr(2'd0, 8'h10);
    pulse_irq();
    check("R4 req with horizontal enable", {7'h0, irq_req}, 8'h01);
    wr(2'd0, 8'h20);
    check("R5 retrigger vertical only", {7'h0, irq_req}, 8'h01);
    wr(2'd0, 8'h30);
    check("R5 no retrigger with both", {7'h0, irq_req}, 8'h00);
  endtask

  task automatic t_irq_off;
    wr(2'd0, 8'h00);
    rd(2'd2);
    check("R6 flag cleared by disable", got, 8'h00);
    wr(2'd0, 8'h20);
    @(negedge clk); reg_addr = 2'd0; wr_data = 8'h00; wr_en = 1'b1; irq_evt = 1'b1;
    @(negedge clk); wr_en = 1'b0; irq_evt = 1'b0; bus_q = 8'h00;
    check("R6 req suppressed", {7'h0, irq_req}, 8'h00);
    rd(2'd2);
    check("R6 flag stays clear", got, 8'h00);
  endtask

  task automatic t_set_wins;
    rd(2'd1);
    @(negedge clk); reg_addr = 2'd1; rd_en = 1'b1; nmi_evt = 1'b1;
    @(negedge clk); rd_en = 1'b0; nmi_evt = 1'b0;
    check("R9 old value returned", rd_data[7:4], 4'h0 | {1'b0, bus_q[6:4]});
    bus_q = rd_data;
    rd(2'd1);
    check("R9 flag kept set", {7'h0, got[7]}, 8'h01);
  endtask

  task automatic t_vblank;
    wr(2'd3, 8'h00);
    hcount = 11'd500;
    overscan = 1'b0;
    vcount = 9'd224; rd(2'd3); check("R10 line 224", got, 8'h00);
    vcount = 9'd225; rd(2'd3); check("R10 line 225", got, 8'h81);
    vcount = 9'd227; rd(2'd3); check("R10 line 227", got, 8'h81);
    vcount = 9'd228; rd(2'd3); check("R10 line 228", got, 8'h80);
    overscan = 1'b1;
    vcount = 9'd239; rd(2'd3); check("R10 overscan 239", got, 8'h00);
    vcount = 9'd240; rd(2'd3); check("R10 overscan 240", got, 8'h81);
    vcount = 9'd243; rd(2'd3); check("R10 overscan 243", got, 8'h80);
    overscan = 1'b0; vcount = 9'd0;
  endtask

  task automatic t_hblank;
    wr(2'd3, 8'h00);
    hcount = 11'd2;    rd(2'd3); check("R11 h 2", got, 8'h40);
    wr(2'd3, 8'h00);
    hcount = 11'd3;    rd(2'd3); check("R11 h 3", got, 8'h00);
    hcount = 11'd1095; rd(2'd3); check("R11 h 1095", got, 8'h00);
    hcount = 11'd1096; rd(2'd3); check("R11 h 1096", got, 8'h40);
    hcount = 11'd500;
    wr(2'd3, 8'hFF);
    rd(2'd3); check("R11 bus bits 5:1", got, 8'h3E);
  endtask

  task automatic t_bus;
    wr(2'd2, 8'h5A);
    rd(2'd0); check("R12 write kept", got, 8'h5A);
    rd(2'd0); check("R12 read kept", got, 8'h5A);
    rd(2'd2); check("R12 irq low bits", got, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_nmi();
    t_nmi_retrig();
    t_irq();
    t_irq_off();
    t_set_wins();
    t_vblank();
    t_hblank();
    t_bus();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule